// File: doc/BRIEF.md
# Two-Bit Attention-Paced Serial Transmitter

This block is the device end of a fast transfer over a three-wire open-collector bus. The host owns the attention line. The device may pull the clock and data lines low, which the bus reads as asserted. A hardware gate on the device asserts the data line whenever the attention level differs from a device-held acknowledge bit. The host asks for more data by flipping attention. The device answers by setting its acknowledge bit equal to attention, which lets the data line go. After a short quiet interval, the device places two payload bits on the bus, using both the clock and data lines as carriers.

Bytes come in on a valid/ready stream. Each byte leaves as a fixed number of bit pairs, most significant pair first. If the stream has nothing to offer when a request arrives, the device leaves its acknowledge bit mismatched. The gate then keeps the data line asserted, and the host stalls until a byte turns up. Attention is brought into the clock domain through a configurable synchronizer. The acknowledge gate itself acts on the raw attention level, as it would in hardware.

Top module: `attn_pair_tx`

## Requirements
- R1: After reset the acknowledge bit is 0, neither bus line is pulled, and `in_ready` is 1.
- R2: A request is a synchronized attention level that differs from the acknowledge bit. Once a pair is available, the acknowledge bit is set to that attention level, and the data line is released.
- R3: For `GUARD_CYC` cycles after the acknowledge bit changes, the device pulls neither the clock line nor the data line.
- R4: After the quiet interval, the clock line carries the higher bit of the pair and the data line carries the lower bit. A bit value of 1 means the line is pulled, that is, asserted.
- R5: A presented pair stays unchanged on both lines until the host flips attention again.
- R6: A byte of `DATA_W` bits goes out as `DATA_W/2` pairs. The first pair is bits [DATA_W-1:DATA_W-2], and each later pair is the next two lower bits.
- R7: While no byte is available, a pending request keeps the acknowledge bit different from attention, and the data line stays asserted.
- R8: A byte is taken on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 1 when no pairs are left, and also when the last pair is being consumed in that same cycle. Every accepted byte reaches the host once, unaltered, and in order.
- R9: The cycle after a changed attention level is seen through the synchronizer, the device stops driving the presented pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| atn_i | input | 1 | Raw attention level from the host, 1 = asserted |
| clk_pull_o | output | 1 | Pull on the shared clock line, 1 = asserted |
| data_pull_o | output | 1 | Pull on the shared data line: gate output ORed with the payload bit |
| ack_o | output | 1 | Device acknowledge bit fed to the gate |

## Verification
Two events can land on the same clock edge: the last pair of a byte is consumed, and a fresh byte is loaded into the emptied holding register. The bench provokes this by keeping `in_valid` high with short or zero gaps, so that the next byte waits at the edge where the final pair is taken. A correct handover shows up at the host as an unbroken, in-order byte stream, checked against a scoreboard queue. A lost or duplicated byte would appear as a pair mismatch or a miscompare.

// File: rtl/attn_tx_pkg.sv
package attn_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_GUARD = 2'd2,
        ST_SHOW  = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } bit_pair_t;

    function automatic int unsigned pair_count(int unsigned width);
        return width / 2;
    endfunction

    function automatic bit_pair_t split_pair(logic [1:0] bits);
        bit_pair_t p;
        p.hi = bits[1];
        p.lo = bits[0];
        return p;
    endfunction

endpackage

// File: rtl/attn_tx_sync.sv
module attn_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/attn_tx_pair_src.sv
module attn_tx_pair_src
    import attn_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pop_i,
    output logic              avail_o,
    output bit_pair_t         head_o
);
    localparam int PAIRS = pair_count(DATA_W);
    localparam int CW    = $clog2(PAIRS + 1);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     left;
    logic              load;

    assign avail_o  = (left != '0);
    assign in_ready = (left == '0) || ((left == CW'(1)) && pop_i);
    assign load     = in_valid && in_ready;
    assign head_o   = split_pair(shreg[DATA_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= in_data;
            left  <= CW'(PAIRS);
        end else if (pop_i && avail_o) begin
            shreg <= {shreg[DATA_W-3:0], 2'b00};
            left  <= left - CW'(1);
        end
    end
endmodule

// File: rtl/attn_tx_guard.sv
module attn_tx_guard #(
    parameter int GUARD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(GUARD_CYC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign done_o = run && (cnt == CW'(GUARD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start_i) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (done_o) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/attn_tx_fsm.sv
module attn_tx_fsm
    import attn_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      atn_sync_i,
    input  logic      avail_i,
    input  bit_pair_t head_i,
    input  logic      guard_done_i,
    output logic      pop_o,
    output logic      guard_start_o,
    output logic      ack_o,
    output logic      show_o,
    output bit_pair_t pair_o
);
    hs_state_e state, nxt;
    logic      ack_q;
    bit_pair_t pair_q;
    logic      pending;

    assign pending = (atn_sync_i != ack_q);

    always_comb begin
        nxt           = state;
        pop_o         = 1'b0;
        guard_start_o = 1'b0;
        case (state)
            ST_IDLE:  if (pending) nxt = ST_PREP;
            ST_PREP: begin
                if (avail_i) begin
                    pop_o         = 1'b1;
                    guard_start_o = 1'b1;
                    nxt           = ST_GUARD;
                end
            end
            ST_GUARD: if (guard_done_i) nxt = ST_SHOW;
            ST_SHOW:  if (pending) nxt = ST_PREP;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ack_q  <= 1'b0;
            pair_q <= '0;
        end else begin
            state <= nxt;
            if (pop_o) begin
                ack_q  <= atn_sync_i;
                pair_q <= head_i;
            end
        end
    end

    assign ack_o  = ack_q;
    assign show_o = (state == ST_SHOW);
    assign pair_o = pair_q;
endmodule

// File: rtl/attn_pair_tx.sv
module attn_pair_tx
    import attn_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int GUARD_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              atn_i,
    output logic              clk_pull_o,
    output logic              data_pull_o,
    output logic              ack_o
);
    logic      atn_s;
    logic      avail;
    logic      pop;
    logic      g_start;
    logic      g_done;
    logic      show;
    bit_pair_t head;
    bit_pair_t pair;

    attn_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (atn_i),
        .sync_o  (atn_s)
    );

    attn_tx_pair_src #(.DATA_W(DATA_W)) u_src (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .pop_i    (pop),
        .avail_o  (avail),
        .head_o   (head)
    );

    attn_tx_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .start_i (g_start),
        .done_o  (g_done)
    );

    attn_tx_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .atn_sync_i    (atn_s),
        .avail_i       (avail),
        .head_i        (head),
        .guard_done_i  (g_done),
        .pop_o         (pop),
        .guard_start_o (g_start),
        .ack_o         (ack_o),
        .show_o        (show),
        .pair_o        (pair)
    );

    // acknowledge gate: asserts data while raw attention and ack differ
    assign data_pull_o = (atn_i ^ ack_o) | (show & pair.lo);
    assign clk_pull_o  = show & pair.hi;
endmodule

// File: rtl/attn_pair_tx_chk.sv
module attn_pair_tx_chk (
    input logic clk,
    input logic rst,
    input logic atn_s,
    input logic ack,
    input logic show,
    input logic clk_pull
);
    // R2: acknowledge only ever moves to the synchronized attention level
    a_r2_ack_follows: assert property (@(posedge clk) disable iff (rst)
        $changed(ack) |-> (ack == $past(atn_s)));

    // R3: no pair on the bus in the cycle the acknowledge bit moves
    a_r3_guard_quiet: assert property (@(posedge clk) disable iff (rst)
        $changed(ack) |-> (!show && !clk_pull));

    // R5: presented clock bit stays put while showing
    a_r5_pair_stable: assert property (@(posedge clk) disable iff (rst)
        (show && $past(show)) |-> $stable(clk_pull));

    // R9: pair withdrawn one cycle after a new request is seen
    a_r9_withdraw: assert property (@(posedge clk) disable iff (rst)
        (atn_s != ack) |=> !show);
endmodule

bind attn_pair_tx attn_pair_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .atn_s    (atn_s),
    .ack      (ack_o),
    .show     (show),
    .clk_pull (clk_pull_o)
);

// File: tb/attn_pair_tx_tb.sv
module attn_pair_tx_tb;
    localparam int DW     = 8;
    localparam int GC     = 2;
    localparam int SS     = 2;
    localparam int NPAIR  = DW / 2;
    localparam int NBYTES = 150;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          atn = 1'b0;
    logic          clk_pull, data_pull, ack;
    logic          bystander_clk = 1'b0;
    logic          bystander_data = 1'b0;

    // wired-OR bus: asserted if any device pulls
    wire clk_line  = clk_pull  | bystander_clk;
    wire data_line = data_pull | bystander_data;

    always #4 clk = ~clk;

    attn_pair_tx #(.DATA_W(DW), .GUARD_CYC(GC), .SYNC_STAGES(SS)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .atn_i       (atn),
        .clk_pull_o  (clk_pull),
        .data_pull_o (data_pull),
        .ack_o       (ack)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] exp_q[$];
    bit            drv_go = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // driver: offers bytes, pushes accepted ones into the scoreboard
    initial begin
        logic [DW-1:0] b;
        wait (drv_go);
        for (int i = 0; i < NBYTES; i++) begin
            if (i == 0)      b = 8'b10_01_11_00;
            else if (i == 1) b = 8'hFF;
            else if (i == 2) b = 8'h00;
            else             b = DW'($urandom);
            if (i > 3) repeat ($urandom_range(0, 6)) @(negedge clk);
            @(negedge clk);
            in_data  = b;
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            exp_q.push_back(b);           // R8: accepted at the next edge
            @(negedge clk);
            in_valid = 1'b0;
        end
    end

    // host receiver / monitor
    initial begin
        logic [DW-1:0] got;
        logic          hi, lo;
        logic [DW-1:0] want;
        logic [1:0]    want_pair;
        bit            first = 1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0,       "R1 ack",   32'(ack), 0);
        chk(clk_line == 1'b0,  "R1 clk",   32'(clk_line), 0);
        chk(data_line == 1'b0, "R1 data",  32'(data_line), 0);
        chk(in_ready == 1'b1,  "R1 ready", 32'(in_ready), 1);

        // R7: request with nothing to send stalls the host
        atn = ~atn;
        repeat (20) begin
            @(negedge clk);
            chk(data_line == 1'b1, "R7 data held", 32'(data_line), 1);
        end
        chk(ack != atn, "R7 ack mismatched", 32'(ack), 32'(~atn));
        drv_go = 1;

        for (int bi = 0; bi < NBYTES; bi++) begin
            got = '0;
            for (int k = 0; k < NPAIR; k++) begin
                if (!first) begin
                    repeat ($urandom_range(0, 6)) begin
                        @(negedge clk);
                        chk(clk_line == hi && data_line == lo, "R5 pair held",
                            {30'd0, clk_line, data_line}, {30'd0, hi, lo});
                    end
                    atn = ~atn;
                    repeat (SS + 1) @(negedge clk);
                    chk(clk_line == 1'b0, "R9 pair withdrawn", 32'(clk_line), 0);
                end
                first = 0;
                while (data_line != 1'b0) @(negedge clk);
                chk(ack == atn, "R2 ack matches", 32'(ack), 32'(atn));
                chk(clk_line == 1'b0 && data_line == 1'b0, "R3 guard quiet",
                    {30'd0, clk_line, data_line}, 0);
                repeat (GC - 1) begin
                    @(negedge clk);
                    chk(clk_line == 1'b0 && data_line == 1'b0, "R3 guard quiet",
                        {30'd0, clk_line, data_line}, 0);
                end
                @(negedge clk);
                hi = clk_line;
                lo = data_line;
                want = (exp_q.size() != 0) ? exp_q[0] : '0;
                want_pair = want[DW-1-2*k -: 2];
                chk(exp_q.size() != 0, "R8 byte known", 32'(exp_q.size()), 1);
                chk({hi, lo} == want_pair, "R4 R6 pair value",
                    {30'd0, hi, lo}, {30'd0, want_pair});
                got = {got[DW-3:0], hi, lo};
            end
            want = (exp_q.size() != 0) ? exp_q.pop_front() : '0;
            chk(got == want, "R8 byte intact", 32'(got), 32'(want));
        end
        finish_run();
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule